// File: doc/BRIEF.md
# Main CPU I/O Decoder with Guarded Nibble NVRAM

This block sits on the address and data buses of an 8-bit CPU with a 16-bit address space. It covers the I/O page near 0xC800–0xCFFF. It decodes two peripheral-interface windows into chip selects and holds a set of small control latches: a 4-bit bank page, an 8-bit LED pattern, and three video control registers. It also holds a watchdog that the CPU must service, and a 1K×4 non-volatile RAM. A switch input guards the first quarter of that RAM.

Several latch ports are read-sensitive. A read of the page, LED or watchdog port acts as a write of the undriven bus value, which is 0xFF. So a read sets the page to 0xF, clears the LED pattern, and never services the watchdog. The watchdog counts a vertical-tick input. If eight ticks pass without a valid service write, it requests a reset. Read data is registered and appears on the cycle after the read strobe.

Top module: `cpu_io_decoder`

## Requirements
- R1: While reset is asserted, and directly after it, the page, LED, image page, translate and both disable outputs are zero. Read data is 0xFF, both chip selects are low and the watchdog reset is low.
- R2: Any access whose address masked with 0xFF80 equals 0xC800 loads the page output from data bits 3:0 at the clock edge.
- R3: Any access whose address masked with 0xFF80 equals 0xC880 loads the LED output with the data inverted and bit-reversed. Output bit i equals the inverse of data bit 7-i.
- R4: A read of the page, LED or watchdog port behaves as a write of 0xFF. The page becomes 0xF, the LED output becomes 0x00, and the watchdog is not serviced.
- R5: The first peripheral select is high in the same cycle as a read or write strobe whose address masked with 0xFF8C equals 0xC980. The second is high when that masked address equals 0xC984. The two selects are never high together, and neither is high without a strobe.
- R6: The video registers are write-only and keep only part of each write. The image page is selected by address masked with 0xFFF1 equal to 0xCBC0 and keeps bits 4:0. The translate register is selected by the same mask equal to 0xCBC1 and keeps bits 5:0. The disable register is selected by address masked with 0xFFF0 equal to 0xCBD0; data bit 0 sets the background disable and bit 1 sets the expander disable. Reads of these addresses change nothing.
- R7: Writes to 0xCC00–0xCFFF store data bits 3:0 at offset address bits 9:0. A read there returns the stored nibble in bits 3:0 and 0xF in bits 7:4, on the cycle after the read strobe.
- R8: When the active-low guard input is low, NVRAM writes whose address bits 9:8 are both zero leave the stored nibble unchanged. Writes to other offsets, and all writes while the guard is high, are stored.
- R9: Each vertical tick advances the watchdog. On the clock edge that samples the eighth tick since the last service or expiry, the reset request rises for exactly one cycle, and counting starts again from zero.
- R10: A write to the watchdog port (address masked with 0xFF80 equal to 0xC900) services the watchdog only when the data masked with 0x3E equals 0x2A. A service clears the tick count and takes priority over a tick in the same cycle. Any other data has no effect.
- R11: A read outside the NVRAM returns 0xFF. Read data holds its value until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | CPU address |
| wdata | input | 8 | CPU write data |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| guard_n | input | 1 | NVRAM guard switch, active low |
| vtick | input | 1 | Vertical tick that advances the watchdog |
| rdata | output | 8 | Registered read data |
| per0_cs | output | 1 | First peripheral window select |
| per1_cs | output | 1 | Second peripheral window select |
| page | output | 4 | Bank page latch |
| led | output | 8 | LED latch |
| img_page | output | 5 | Image page register |
| xlate | output | 6 | Translate register |
| bg_dis | output | 1 | Background disable |
| exp_dis | output | 1 | Expander disable |
| wdog_rst | output | 1 | One-cycle watchdog reset request |

## Verification
The assertions take for granted that the read and write strobes are never high in the same cycle. They also assume the address and data are steady for the whole strobe cycle. A property checks the first assumption. The stimulus drives every access from a single task that raises exactly one strobe for one cycle, with address and data set half a cycle earlier. The vertical tick is held low outside the watchdog sequences, so the guard-window and service properties only see counts that the bench itself controls.

// File: rtl/iodec_pkg.sv
package iodec_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  typedef enum logic [3:0] {
    RG_NONE, RG_PAGE, RG_LED, RG_WDOG, RG_PER0, RG_PER1,
    RG_IMG, RG_XLATE, RG_DIS, RG_NVRAM
  } region_e;

  localparam logic [ADDR_W-1:0] M_LATCH  = 16'hFF80;
  localparam logic [ADDR_W-1:0] M_PER    = 16'hFF8C;
  localparam logic [ADDR_W-1:0] M_VIDREG = 16'hFFF1;
  localparam logic [ADDR_W-1:0] M_DIS    = 16'hFFF0;
  localparam logic [ADDR_W-1:0] M_NV     = 16'hFC00;

  localparam logic [ADDR_W-1:0] A_PAGE  = 16'hC800;
  localparam logic [ADDR_W-1:0] A_LED   = 16'hC880;
  localparam logic [ADDR_W-1:0] A_WDOG  = 16'hC900;
  localparam logic [ADDR_W-1:0] A_PER0  = 16'hC980;
  localparam logic [ADDR_W-1:0] A_PER1  = 16'hC984;
  localparam logic [ADDR_W-1:0] A_IMG   = 16'hCBC0;
  localparam logic [ADDR_W-1:0] A_XLATE = 16'hCBC1;
  localparam logic [ADDR_W-1:0] A_DIS   = 16'hCBD0;
  localparam logic [ADDR_W-1:0] A_NV    = 16'hCC00;

  function automatic logic [DATA_W-1:0] bit_flip(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = v[DATA_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/iodec_decode.sv
module iodec_decode
  import iodec_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output region_e           region
);
  always_comb begin
    region = RG_NONE;
    if      ((addr & M_LATCH)  == A_PAGE)  region = RG_PAGE;
    else if ((addr & M_LATCH)  == A_LED)   region = RG_LED;
    else if ((addr & M_LATCH)  == A_WDOG)  region = RG_WDOG;
    else if ((addr & M_PER)    == A_PER0)  region = RG_PER0;
    else if ((addr & M_PER)    == A_PER1)  region = RG_PER1;
    else if ((addr & M_VIDREG) == A_IMG)   region = RG_IMG;
    else if ((addr & M_VIDREG) == A_XLATE) region = RG_XLATE;
    else if ((addr & M_DIS)    == A_DIS)   region = RG_DIS;
    else if ((addr & M_NV)     == A_NV)    region = RG_NVRAM;
  end
endmodule

// File: rtl/iodec_latches.sv
module iodec_latches
  import iodec_pkg::*;
#(
  parameter int PAGE_W = 4,
  parameter int IMG_W  = 5,
  parameter int XL_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  region_e           region,
  input  logic              access,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] bus,
  output logic [PAGE_W-1:0] page_q,
  output logic [DATA_W-1:0] led_q,
  output logic [IMG_W-1:0]  img_q,
  output logic [XL_W-1:0]   xl_q,
  output logic              bg_q,
  output logic              exp_q
);
  logic [PAGE_W-1:0] page_d;
  logic [DATA_W-1:0] led_d;
  logic [IMG_W-1:0]  img_d;
  logic [XL_W-1:0]   xl_d;
  logic              bg_d, exp_d;

  always_comb begin
    page_d = page_q;
    led_d  = led_q;
    img_d  = img_q;
    xl_d   = xl_q;
    bg_d   = bg_q;
    exp_d  = exp_q;
    if (access && region == RG_PAGE) page_d = bus[PAGE_W-1:0];
    if (access && region == RG_LED)  led_d  = bit_flip(~bus);
    if (wr_en && region == RG_IMG)   img_d  = bus[IMG_W-1:0];
    if (wr_en && region == RG_XLATE) xl_d   = bus[XL_W-1:0];
    if (wr_en && region == RG_DIS) begin
      bg_d  = bus[0];
      exp_d = bus[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      led_q  <= '0;
      img_q  <= '0;
      xl_q   <= '0;
      bg_q   <= 1'b0;
      exp_q  <= 1'b0;
    end else begin
      page_q <= page_d;
      led_q  <= led_d;
      img_q  <= img_d;
      xl_q   <= xl_d;
      bg_q   <= bg_d;
      exp_q  <= exp_d;
    end
  end

  p_page_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (access && region == RG_PAGE) |=> page_q == $past(bus[PAGE_W-1:0]));

  p_led_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (access && region == RG_LED) |=> led_q == bit_flip(~$past(bus)));

  p_vid_readonly_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (region == RG_IMG || region == RG_XLATE || region == RG_DIS))
    |=> ($stable(img_q) && $stable(xl_q) && $stable(bg_q) && $stable(exp_q)));
endmodule

// File: rtl/iodec_watchdog.sv
module iodec_watchdog
  import iodec_pkg::*;
#(
  parameter int                TICKS     = 8,
  parameter logic [DATA_W-1:0] KICK_MASK = 8'h3E,
  parameter logic [DATA_W-1:0] KICK_VAL  = 8'h2A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_hit,
  input  logic [DATA_W-1:0] bus,
  input  logic              vtick,
  output logic              fire_q
);
  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          fire_d;
  logic          kick;

  assign kick = port_hit && ((bus & KICK_MASK) == KICK_VAL);

  always_comb begin
    cnt_d  = cnt_q;
    fire_d = 1'b0;
    if (kick) begin
      cnt_d = '0;
    end else if (vtick) begin
      if (cnt_q == LAST) begin
        cnt_d  = '0;
        fire_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      fire_q <= fire_d;
    end
  end

  p_pulse_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |=> !fire_q);

  p_fire_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |-> cnt_q == '0);

  p_kick_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (!fire_q && cnt_q == '0));
endmodule

// File: rtl/iodec_nvram.sv
module iodec_nvram
  import iodec_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int NW    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sel,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] offs,
  input  logic [NW-1:0]            wnib,
  input  logic                     guard_n,
  output logic [NW-1:0]            rnib
);
  localparam int OW = $clog2(DEPTH);

  logic [NW-1:0] mem [DEPTH];
  logic          in_guard;
  logic          we;

  assign in_guard = (offs[OW-1:OW-2] == 2'b00);
  assign we       = sel && wr_en && !(in_guard && !guard_n);
  assign rnib     = mem[offs];

  always_ff @(posedge clk) begin
    if (we) mem[offs] <= wnib;
  end

  p_guard_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_en && !guard_n && in_guard) |=> mem[$past(offs)] == $past(mem[offs]));

  p_open_stores_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_en && !in_guard) |=> mem[$past(offs)] == $past(wnib));
endmodule

// File: rtl/cpu_io_decoder.sv
module cpu_io_decoder
  import iodec_pkg::*;
#(
  parameter int                NV_DEPTH = 1024,
  parameter int                NV_W     = 4,
  parameter int                WD_TICKS = 8,
  parameter logic [DATA_W-1:0] OPEN_BUS = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic              guard_n,
  input  logic              vtick,
  output logic [DATA_W-1:0] rdata,
  output logic              per0_cs,
  output logic              per1_cs,
  output logic [3:0]        page,
  output logic [7:0]        led,
  output logic [4:0]        img_page,
  output logic [5:0]        xlate,
  output logic              bg_dis,
  output logic              exp_dis,
  output logic              wdog_rst
);
  localparam int NV_OW = $clog2(NV_DEPTH);

  region_e           region;
  logic              access;
  logic [DATA_W-1:0] bus;
  logic [NV_W-1:0]   rnib;
  logic [DATA_W-1:0] rdata_d;

  assign access = rd_en | wr_en;
  assign bus    = wr_en ? wdata : OPEN_BUS;

  iodec_decode u_dec (
    .addr   (addr),
    .region (region)
  );

  assign per0_cs = access && (region == RG_PER0);
  assign per1_cs = access && (region == RG_PER1);

  iodec_latches #(.PAGE_W(4), .IMG_W(5), .XL_W(6)) u_lat (
    .clk    (clk),
    .rst_n  (rst_n),
    .region (region),
    .access (access),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .bus    (bus),
    .page_q (page),
    .led_q  (led),
    .img_q  (img_page),
    .xl_q   (xlate),
    .bg_q   (bg_dis),
    .exp_q  (exp_dis)
  );

  iodec_watchdog #(.TICKS(WD_TICKS)) u_wd (
    .clk      (clk),
    .rst_n    (rst_n),
    .port_hit (access && (region == RG_WDOG)),
    .bus      (bus),
    .vtick    (vtick),
    .fire_q   (wdog_rst)
  );

  iodec_nvram #(.DEPTH(NV_DEPTH), .NW(NV_W)) u_nv (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (region == RG_NVRAM),
    .wr_en   (wr_en),
    .offs    (addr[NV_OW-1:0]),
    .wnib    (wdata[NV_W-1:0]),
    .guard_n (guard_n),
    .rnib    (rnib)
  );

  always_comb begin
    rdata_d = rdata;
    if (rd_en) begin
      if (region == RG_NVRAM) rdata_d = {OPEN_BUS[DATA_W-1:NV_W], rnib};
      else                    rdata_d = OPEN_BUS;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= OPEN_BUS;
    else        rdata <= rdata_d;
  end

  p_cs_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({per0_cs, per1_cs}));

  p_cs_needs_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (per0_cs || per1_cs) |-> (rd_en || wr_en));

  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en));

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  p_open_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && region != RG_NVRAM) |=> rdata == OPEN_BUS);
endmodule

// File: tb/cpu_io_decoder_test.sv
module cpu_io_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] addr;
  logic [7:0]  wdata;
  logic        rd_en, wr_en, guard_n, vtick;
  logic [7:0]  rdata;
  logic        per0_cs, per1_cs;
  logic [3:0]  page;
  logic [7:0]  led;
  logic [4:0]  img_page;
  logic [5:0]  xlate;
  logic        bg_dis, exp_dis, wdog_rst;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  cpu_io_decoder uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .rd_en(rd_en),
    .wr_en(wr_en), .guard_n(guard_n), .vtick(vtick), .rdata(rdata),
    .per0_cs(per0_cs), .per1_cs(per1_cs), .page(page), .led(led),
    .img_page(img_page), .xlate(xlate), .bg_dis(bg_dis), .exp_dis(exp_dis),
    .wdog_rst(wdog_rst)
  );

  typedef struct packed {
    logic        wr;
    logic [15:0] a;
    logic [7:0]  d;
    logic [3:0]  pg;
    logic [7:0]  ld;
    logic [4:0]  im;
    logic [5:0]  xl;
    logic [1:0]  dis;
  } vec_t;

  localparam vec_t VEC [18] = '{
    '{1'b1, 16'hC800, 8'h3C, 4'hC, 8'h00, 5'h00, 6'h00, 2'b00},
    '{1'b1, 16'hC87F, 8'hA5, 4'h5, 8'h00, 5'h00, 6'h00, 2'b00},
    '{1'b1, 16'hC880, 8'h01, 4'h5, 8'h7F, 5'h00, 6'h00, 2'b00},
    '{1'b1, 16'hC8FF, 8'hA5, 4'h5, 8'h5A, 5'h00, 6'h00, 2'b00},
    '{1'b1, 16'hCBC0, 8'hFF, 4'h5, 8'h5A, 5'h1F, 6'h00, 2'b00},
    '{1'b1, 16'hCBCE, 8'h2A, 4'h5, 8'h5A, 5'h0A, 6'h00, 2'b00},
    '{1'b1, 16'hCBC1, 8'hFF, 4'h5, 8'h5A, 5'h0A, 6'h3F, 2'b00},
    '{1'b1, 16'hCBCF, 8'h15, 4'h5, 8'h5A, 5'h0A, 6'h15, 2'b00},
    '{1'b1, 16'hCBD0, 8'h01, 4'h5, 8'h5A, 5'h0A, 6'h15, 2'b01},
    '{1'b1, 16'hCBDF, 8'hFE, 4'h5, 8'h5A, 5'h0A, 6'h15, 2'b10},
    '{1'b0, 16'hC800, 8'h00, 4'hF, 8'h5A, 5'h0A, 6'h15, 2'b10},
    '{1'b0, 16'hC8AA, 8'h00, 4'hF, 8'h00, 5'h0A, 6'h15, 2'b10},
    '{1'b1, 16'hC870, 8'h06, 4'h6, 8'h00, 5'h0A, 6'h15, 2'b10},
    '{1'b1, 16'hCBC2, 8'h13, 4'h6, 8'h00, 5'h13, 6'h15, 2'b10},
    '{1'b1, 16'hC880, 8'h0F, 4'h6, 8'h0F, 5'h13, 6'h15, 2'b10},
    '{1'b0, 16'hCBC0, 8'h00, 4'h6, 8'h0F, 5'h13, 6'h15, 2'b10},
    '{1'b0, 16'hCBD5, 8'h00, 4'h6, 8'h0F, 5'h13, 6'h15, 2'b10},
    '{1'b0, 16'hC901, 8'h00, 4'h6, 8'h0F, 5'h13, 6'h15, 2'b10}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_op(input logic wr, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr  = a;
    wdata = d;
    wr_en = wr;
    rd_en = ~wr;
    @(negedge clk);
    wr_en = 1'b0;
    rd_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    vtick = 1'b1;
    @(negedge clk);
    vtick = 1'b0;
  endtask

  task automatic ticks_quiet(input int n, input string tag);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      if (wdog_rst) seen++;
    end
    chk(tag, seen, 0);
  endtask

  task automatic expect_fire(input string tag);
    tick();
    chk(tag, {31'd0, wdog_rst}, 1);
    @(negedge clk);
    chk({tag, " single-cycle"}, {31'd0, wdog_rst}, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL bench-timeout actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; addr = '0; wdata = '0; rd_en = 1'b0; wr_en = 1'b0;
    guard_n = 1'b1; vtick = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 page/led in reset", {page, led}, 12'h000);
    chk("R1 rdata in reset", rdata, 8'hFF);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 video after reset", {img_page, xlate, exp_dis, bg_dis}, 0);
    chk("R1 selects and wdog after reset", {per0_cs, per1_cs, wdog_rst}, 0);

    // Table walk: R2 R3 R4 R6 latch behaviour; R11 read data on reads
    for (int i = 0; i < 18; i++) begin
      bus_op(VEC[i].wr, VEC[i].a, VEC[i].d);
      chk($sformatf("R2 R3 R4 R6 vector %0d", i),
          {page, led, img_page, xlate, exp_dis, bg_dis},
          {VEC[i].pg, VEC[i].ld, VEC[i].im, VEC[i].xl, VEC[i].dis});
      if (!VEC[i].wr) chk($sformatf("R11 R4 open-bus read vector %0d", i), rdata, 8'hFF);
    end

    // R5 chip selects, sampled mid-cycle
    @(negedge clk); addr = 16'hC981; rd_en = 1'b1; #1;
    chk("R5 per0 on read C981", {per0_cs, per1_cs}, 2'b10);
    @(negedge clk); rd_en = 1'b0; addr = 16'hC9F5; wr_en = 1'b1; #1;
    chk("R5 per1 on write C9F5", {per0_cs, per1_cs}, 2'b01);
    @(negedge clk); wr_en = 1'b0; addr = 16'hC988; wr_en = 1'b1; #1;
    chk("R5 no select at C988", {per0_cs, per1_cs}, 2'b00);
    @(negedge clk); wr_en = 1'b0; addr = 16'hC984; #1;
    chk("R5 no select without strobe", {per0_cs, per1_cs}, 2'b00);
    @(negedge clk);
    chk("R11 rdata after peripheral read", rdata, 8'hFF);

    // R7 nibble store and read
    guard_n = 1'b1;
    bus_op(1'b1, 16'hCC10, 8'hA7);
    bus_op(1'b1, 16'hCD20, 8'h5C);
    bus_op(1'b0, 16'hCC10, 8'h00);
    chk("R7 read CC10", rdata, 8'hF7);
    bus_op(1'b0, 16'hCD20, 8'h00);
    chk("R7 read CD20", rdata, 8'hFC);
    @(negedge clk);
    chk("R11 rdata held", rdata, 8'hFC);

    // R8 guard
    guard_n = 1'b0;
    bus_op(1'b1, 16'hCC10, 8'h03);
    bus_op(1'b0, 16'hCC10, 8'h00);
    chk("R8 guarded write blocked", rdata, 8'hF7);
    bus_op(1'b1, 16'hCD20, 8'h09);
    bus_op(1'b0, 16'hCD20, 8'h00);
    chk("R8 unguarded quarter writes", rdata, 8'hF9);
    bus_op(1'b1, 16'hCF3F, 8'h0E);
    bus_op(1'b0, 16'hCF3F, 8'h00);
    chk("R8 top quarter writes", rdata, 8'hFE);
    guard_n = 1'b1;
    bus_op(1'b1, 16'hCC10, 8'h03);
    bus_op(1'b0, 16'hCC10, 8'h00);
    chk("R8 guard released writes", rdata, 8'hF3);

    // R9 expiry after eight ticks
    bus_op(1'b1, 16'hC900, 8'h2A);
    ticks_quiet(7, "R9 no reset before 8th tick");
    expect_fire("R9 reset on 8th tick");
    ticks_quiet(7, "R9 restart after expiry");
    // R10 valid service (0xEB masked 0x3E -> 0x2A) at a mirror address
    bus_op(1'b1, 16'hC97F, 8'hEB);
    ticks_quiet(7, "R10 valid service clears count");
    expect_fire("R10 reset 8 ticks after service");
    // R10 invalid data and R4 read do not service
    ticks_quiet(4, "R10 first four ticks");
    bus_op(1'b1, 16'hC900, 8'h2E);
    bus_op(1'b0, 16'hC900, 8'h00);
    ticks_quiet(3, "R10 R4 invalid service ignored");
    expect_fire("R10 R4 reset despite invalid service");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule